// File: doc/BRIEF.md
# Interleaved Four-Bank Line Fill Controller

This block sits on the memory side of a cache and answers line-fill requests. A request carries the address of a block. Each block holds four words, and word `i` of every block is stored in bank `i`, so all four words of one block sit at the same row of four separate one-word-wide banks. After one address cycle the controller starts all four bank accesses together. When the fixed access latency has run out it sends the four words, one per clock, in ascending order over a one-word response bus, and it flags the last word.

The response stream has no back-pressure. While a fill is in progress the request port is not ready. A parameter selects a serialized mode that models a single one-word-wide bank for comparison: it waits out the full access latency before each word. A simple single-word store port writes the bank arrays directly. After reset every word holds a known pattern derived from its own word address.

Top module: `interleaved_fill`

## Requirements
- R1: During and right after reset, `req_ready_o` is 1 and `rsp_valid_o` and `rsp_last_o` are 0.
- R2: The word address is `{block, i}`, and the two low bits `i` select the bank. After reset, the word at address `a` reads back as `a ^ INIT_XOR`, with `a` zero-extended to the data width.
- R3: In interleaved mode (`SERIAL_MODE=0`), take the edge that accepts a request as cycle 0. The four beats appear in cycles 16, 17, 18 and 19 with no gap, so the fill occupies 1 + 15 + 4 = 20 cycles.
- R4: The beats carry words 0, 1, 2 and 3 of the block, in that order. `rsp_last_o` is 1 on the fourth beat only and is never 1 without `rsp_valid_o`.
- R5: `req_ready_o` drops in the cycle after acceptance and stays low through the last beat. A request presented while it is low is ignored: the current fill is unchanged and no extra beats follow. `req_ready_o` returns to 1 in the cycle after the last beat.
- R6: In serialized mode (`SERIAL_MODE=1`), the beats appear in cycles 16, 32, 48 and 64, and `req_ready_o` returns in cycle 65, for 65 cycles in total.
- R7: A store with `st_en_i`=1 writes `st_data_i` to word address `st_addr_i` at the clock edge. Any later fill that covers that word returns the new value.
- R8: A store taken at the same edge that accepts a request is reflected in that request's returned words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fill request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_blk_i | input | ROW_W | Block address of the request |
| st_en_i | input | 1 | Single-word store enable |
| st_addr_i | input | ROW_W+2 | Word address of the store |
| st_data_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_data_o | output | DATA_W | Response word |
| rsp_last_o | output | 1 | Final beat of the block |

## Verification
Two functions can fall in the same clock edge: a store writing a bank array, and the acceptance of a fill request for the block that holds the stored word. The bench drives both at once, with a store into the requested block, and expects the fill to return the new word. Independently of that, a second request is raised while each fill is busy, and the bench expects the beat count, order and timing of the running fill to stay unchanged. Both modes are instantiated side by side on the same stimulus, and each beat is judged by its exact cycle offset from acceptance.

// File: rtl/iv_pkg.sv
package iv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACC,
    ST_XFER
  } fill_state_e;
endpackage

// File: rtl/iv_bank.sv
module iv_bank #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ROW_W     = 4,
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_ID   = 0,
  parameter logic [DATA_W-1:0] INIT_XOR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_en_i,
  input  logic [ROW_W-1:0]  st_row_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              ld_en_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned ROWS = 1 << ROW_W;

  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++)
        mem_q[r] <= DATA_W'(r * NUM_BANKS + BANK_ID) ^ INIT_XOR;
    end else if (st_en_i) begin
      mem_q[st_row_i] <= st_data_i;
    end
  end

  // data-ready register, loaded when the access latency expires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (ld_en_i) rd_data_o <= mem_q[rd_row_i];
  end
endmodule

// File: rtl/iv_seq.sv
module iv_seq
  import iv_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned ACCESS_LAT  = 15,
  parameter bit          SERIAL_MODE = 1'b0,
  localparam int unsigned SEL_W = $clog2(NUM_BANKS),
  localparam int unsigned CNT_W = $clog2(ACCESS_LAT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_fire_i,
  output logic                 busy_o,
  output logic [NUM_BANKS-1:0] load_o,
  output logic                 beat_valid_o,
  output logic [SEL_W-1:0]     beat_idx_o,
  output logic                 beat_last_o
);
  fill_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEL_W-1:0] idx_q, idx_d;
  logic acc_done;

  assign acc_done     = (state_q == ST_ACC) && (cnt_q == CNT_W'(ACCESS_LAT - 1));
  assign busy_o       = (state_q != ST_IDLE);
  assign beat_valid_o = (state_q == ST_XFER);
  assign beat_idx_o   = idx_q;
  assign beat_last_o  = beat_valid_o && (idx_q == SEL_W'(NUM_BANKS - 1));

  generate
    if (SERIAL_MODE) begin : g_serial
      always_comb begin
        load_o = '0;
        load_o[idx_q] = acc_done;
      end
    end else begin : g_parallel
      assign load_o = {NUM_BANKS{acc_done}};
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (req_fire_i) begin
        state_d = ST_ADDR;
        idx_d   = '0;
      end
      ST_ADDR: begin
        state_d = ST_ACC;
        cnt_d   = '0;
      end
      ST_ACC: begin
        if (acc_done) state_d = ST_XFER;
        else          cnt_d   = cnt_q + 1'b1;
      end
      ST_XFER: begin
        if (beat_last_o) begin
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          if (SERIAL_MODE) begin
            state_d = ST_ACC;
            cnt_d   = '0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/interleaved_fill.sv
module interleaved_fill #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ROW_W       = 4,
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned ACCESS_LAT  = 15,
  parameter bit          SERIAL_MODE = 1'b0,
  parameter logic [DATA_W-1:0] INIT_XOR = 32'hC0DE_0000,
  localparam int unsigned SEL_W  = $clog2(NUM_BANKS),
  localparam int unsigned ADDR_W = ROW_W + SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ROW_W-1:0]  req_blk_i,
  input  logic              st_en_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_last_o
);
  logic                 busy;
  logic                 req_fire;
  logic [NUM_BANKS-1:0] load;
  logic [SEL_W-1:0]     beat_idx;
  logic [ROW_W-1:0]     blk_q;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

  assign req_ready_o = !busy;
  assign req_fire    = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       blk_q <= '0;
    else if (req_fire) blk_q <= req_blk_i;
  end

  iv_seq #(
    .NUM_BANKS  (NUM_BANKS),
    .ACCESS_LAT (ACCESS_LAT),
    .SERIAL_MODE(SERIAL_MODE)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_fire_i  (req_fire),
    .busy_o      (busy),
    .load_o      (load),
    .beat_valid_o(rsp_valid_o),
    .beat_idx_o  (beat_idx),
    .beat_last_o (rsp_last_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic st_hit;
    assign st_hit = st_en_i && (st_addr_i[SEL_W-1:0] == SEL_W'(b));
    iv_bank #(
      .DATA_W   (DATA_W),
      .ROW_W    (ROW_W),
      .NUM_BANKS(NUM_BANKS),
      .BANK_ID  (b),
      .INIT_XOR (INIT_XOR)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .st_en_i  (st_hit),
      .st_row_i (st_addr_i[ADDR_W-1:SEL_W]),
      .st_data_i(st_data_i),
      .ld_en_i  (load[b]),
      .rd_row_i (blk_q),
      .rd_data_o(bank_rd[b])
    );
  end

  assign rsp_data_o = bank_rd[beat_idx];
endmodule

// File: rtl/iv_fill_chk.sv
module iv_fill_chk #(
  parameter bit SERIAL_MODE = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic rsp_valid_o,
  input logic rsp_last_o
);
  // R4
  last_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> rsp_valid_o);

  // R5
  busy_during_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  // R5
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R5
  ready_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |=> req_ready_o);

  // R3
  beats_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!SERIAL_MODE && rsp_valid_o && !rsp_last_o) |=> rsp_valid_o);

  // R6
  beats_spaced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SERIAL_MODE && rsp_valid_o) |=> !rsp_valid_o);
endmodule

bind interleaved_fill iv_fill_chk #(.SERIAL_MODE(SERIAL_MODE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_last_o (rsp_last_o)
);

// File: tb/interleaved_fill_test.sv
`timescale 1ns/1ps
module interleaved_fill_test;
  localparam int DW = 32;
  localparam int RW = 4;
  localparam int AW = RW + 2;
  localparam logic [31:0] XORV = 32'hC0DE_0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [RW-1:0] req_blk = '0;
  logic st_en = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic rdy_p, val_p, last_p, rdy_s, val_s, last_s;
  logic [DW-1:0] dat_p, dat_s;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #2 clk = ~clk;

  interleaved_fill #(.SERIAL_MODE(1'b0), .INIT_XOR(XORV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(rdy_p),
    .req_blk_i(req_blk), .st_en_i(st_en), .st_addr_i(st_addr), .st_data_i(st_data),
    .rsp_valid_o(val_p), .rsp_data_o(dat_p), .rsp_last_o(last_p));

  interleaved_fill #(.SERIAL_MODE(1'b1), .INIT_XOR(XORV)) uut_serial (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(rdy_s),
    .req_blk_i(req_blk), .st_en_i(st_en), .st_addr_i(st_addr), .st_data_i(st_data),
    .rsp_valid_o(val_s), .rsp_data_o(dat_s), .rsp_last_o(last_s));

  function automatic logic [DW-1:0] init_word(int a);
    return DW'(a) ^ XORV;
  endfunction

  function automatic int beat_cycle(bit serial, int j);
    return serial ? 16 + 16 * j : 16 + j;
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_store(int a, logic [DW-1:0] d);
    @(negedge clk);
    st_en = 1'b1; st_addr = AW'(a); st_data = d;
    @(posedge clk);
    ref_mem[a] = d;
    @(negedge clk);
    st_en = 1'b0;
  endtask

  // one fill on both instances; optional store at the accepting edge (R8)
  task automatic do_fill(int blk, bit same_st, int sa, logic [DW-1:0] sd);
    int np = 0;
    int ns = 0;
    @(negedge clk);
    chk(rdy_p && rdy_s, "R5 idle before request", {30'd0, rdy_p, rdy_s}, 32'd3);
    req_valid = 1'b1; req_blk = RW'(blk);
    st_en = same_st; st_addr = AW'(sa); st_data = sd;
    @(posedge clk);
    if (same_st) ref_mem[sa] = sd;
    for (int c = 0; c < 70; c++) begin
      @(negedge clk);
      if (c == 0) begin req_valid = 1'b0; st_en = 1'b0; end
      if (c == 5) begin req_valid = 1'b1; req_blk = RW'(blk ^ 1); end
      if (c == 6) req_valid = 1'b0;
      if (val_p) begin
        chk(np < 4 && c == beat_cycle(0, np), "R3 beat cycle", c, beat_cycle(0, np));
        chk(dat_p == ref_mem[blk * 4 + (np & 3)], "R4 word order/data (R2 R7 R8)",
            dat_p, ref_mem[blk * 4 + (np & 3)]);
        chk(last_p == (np == 3), "R4 last flag", last_p, np == 3);
        np++;
      end else begin
        chk(!last_p, "R4 last without valid", last_p, 0);
      end
      if (val_s) begin
        chk(ns < 4 && c == beat_cycle(1, ns), "R6 beat cycle", c, beat_cycle(1, ns));
        chk(dat_s == ref_mem[blk * 4 + (ns & 3)], "R6 serial data", dat_s,
            ref_mem[blk * 4 + (ns & 3)]);
        chk(last_s == (ns == 3), "R4 serial last flag", last_s, ns == 3);
        ns++;
      end
      if (c == 19) chk(!rdy_p, "R5 busy through last beat", rdy_p, 0);
      if (c == 20) chk(rdy_p, "R5 ready after last beat", rdy_p, 1);
      if (c == 64) chk(!rdy_s, "R6 busy through last beat", rdy_s, 0);
      if (c == 65) chk(rdy_s, "R6 ready after 65 cycles", rdy_s, 1);
    end
    chk(np == 4, "R5 exactly four beats, busy request ignored", np, 4);
    chk(ns == 4, "R6 exactly four serial beats", ns, 4);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) ref_mem[a] = init_word(a);
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1
    chk(rdy_p && rdy_s && !val_p && !val_s && !last_p && !last_s, "R1 reset state",
        {26'd0, rdy_p, rdy_s, val_p, val_s, last_p, last_s}, 32'h30);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rdy_p && !val_p && rdy_s && !val_s, "R1 after reset", {30'd0, rdy_p, val_p}, 32'd2);

    do_fill(0, 0, 0, '0);                    // R2 reset pattern, block 0
    do_fill((1 << RW) - 1, 0, 0, '0);        // R2 top block
    do_store(5 * 4 + 2, 32'hDEAD_BEEF);      // R7
    do_store(5 * 4 + 0, 32'h1234_5678);
    do_fill(5, 0, 0, '0);
    do_fill(9, 1, 9 * 4 + 3, 32'hFACE_0FF0); // R8 same-edge store
    do_fill(9, 1, 3 * 4 + 1, 32'h0BAD_CAFE); // R8 store elsewhere, R7 later
    do_fill(3, 0, 0, '0);

    for (int it = 0; it < 14; it++) begin
      int nst = $urandom_range(0, 3);
      int blk = $urandom_range(0, (1 << RW) - 1);
      for (int s = 0; s < nst; s++) begin
        int sa = (s == 0) ? blk * 4 + $urandom_range(0, 3) : $urandom_range(0, (1 << AW) - 1);
        do_store(sa, $urandom);
      end
      if ($urandom_range(0, 1) == 1)
        do_fill(blk, 1, blk * 4 + $urandom_range(0, 3), $urandom);
      else
        do_fill(blk, 0, 0, '0);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule